// File: doc/BRIEF.md
# Message-signalled interrupt vector table controller

This block turns interrupt requests from a device function into memory-write messages. It keeps a table of N vector entries. Each entry holds a 64-bit message address, a 32-bit message data word and a per-vector mask bit. It also keeps an array of pending bits, one per vector. Software reaches both through 32-bit little-endian register reads and writes. A 16-bit control field holds the enable bit and the function-wide mask bit and reports the table size.

When the device raises a request for a vector, the block first checks that the vector exists and is marked in use by the device. It then checks the vector's effective mask. A masked vector gets its pending bit set. An unmasked vector queues one write of the entry's data to the entry's address. The write goes out on a single-beat request/acknowledge master port.

When a vector changes from masked to unmasked and its pending bit is set, the pending bit is cleared and the message is queued. The change can come from a table write or from a control write. Queued messages leave one at a time, lowest vector first. Each one waits for the acknowledge before the next is presented.

Top module: `msgtab_top`

## Requirements
- R1: After reset the enable and mask-all bits read 0. Every table address and data word reads 0, and every entry's mask bit reads 1. All pending bits read 0. The function-wide mask is asserted, so a request made right after reset sets its pending bit instead of sending a message.
- R2: The control field reads the enable bit at bit 15 and the mask-all bit at bit 14. Bits 10:0 read N-1 and bits 13:11 read 0. A control write loads bits 15 and 14 from the write data.
- R3: The function-wide mask is asserted when enable is 0 or mask-all is 1. A vector is effectively masked when the function-wide mask is asserted or the vector's own mask bit is 1.
- R4: A request with an index of N or more, or for a vector whose in-use input is 0, sends no message and sets no pending bit.
- R5: A request for an effectively unmasked vector sends one message. The message address is entry word 1 (upper half) joined to entry word 0 (lower half), and the data is entry word 2. Address and data stay on the port unchanged while the request is high and unacknowledged.
- R6: A request for an effectively masked vector sets pending bit v and sends nothing. Pending bit v is bit v mod 32 of pending word v/32, which is byte v/8, bit v mod 8 in little-endian order. Repeated requests leave one bit, which produces one message when the vector is unmasked.
- R7: A table write or a control write that takes a vector from masked to unmasked while its pending bit is set clears that bit and sends the vector's message. A pending bit is only ever held while its vector is masked.
- R8: Messages that are queued together leave in ascending vector order, one request per message, each after the previous acknowledge.
- R9: Table entry v spans bytes 16v to 16v+15. The words at offsets 0, 4, 8 and 12 are address low, address high, data and vector control. Vector control bit 0 is the mask, and its other bits read 0. Table reads at or beyond entry N return 0, and writes there change nothing.
- R10: The pending array is read-only, so writes to it change no bit. It spans N rounded up to a multiple of 64 bits, and bits at index N or above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control field write strobe |
| ctl_wdata | input | 16 | Control field write data |
| ctl_rdata | output | 16 | Control field read value |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Region select: 0 table, 1 pending array |
| reg_addr | input | REG_AW | Byte address inside the region, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel/reg_addr |
| vec_inuse | input | NVEC | Per-vector in-use flags from the device |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | IDX_W | Requested vector index |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_ack | input | 1 | Message accepted |

## Verification
A pending bit that is wrongly set or cleared shows at the ports in two ways. The pending region read changes in the cycle after the request, and a later unmask sends an extra message or leaves one out. A wrong effective mask shows as a message appearing where a pending bit was expected, or the reverse, within a few cycles of the request. A broken replay order or a lost queued vector shows as a mismatch in the sequence of acknowledged messages once the port goes idle.

// File: rtl/msgtab_pkg.sv
package msgtab_pkg;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msgtab_msg_t;

  typedef enum logic {
    ISS_IDLE = 1'b0,
    ISS_BUSY = 1'b1
  } msgtab_iss_e;

  localparam int unsigned CTL_EN_BIT = 15;
  localparam int unsigned CTL_MA_BIT = 14;
  localparam int unsigned CTL_SZ_W   = 11;

endpackage

// File: rtl/msgtab_ctl.sv
module msgtab_ctl
  import msgtab_pkg::*;
#(
  parameter int unsigned NVEC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_wdata,
  output logic [15:0] ctl_rdata,
  output logic        fmask
);

  localparam logic [CTL_SZ_W-1:0] SIZE_CODE = CTL_SZ_W'(NVEC - 1);

  logic en_q, en_d;
  logic ma_q, ma_d;

  always_comb begin
    en_d = en_q;
    ma_d = ma_q;
    if (ctl_wr) begin
      en_d = ctl_wdata[CTL_EN_BIT];
      ma_d = ctl_wdata[CTL_MA_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ma_q <= 1'b0;
    end else begin
      en_q <= en_d;
      ma_q <= ma_d;
    end
  end

  assign fmask     = ~en_q | ma_q;
  assign ctl_rdata = {en_q, ma_q, 3'b000, SIZE_CODE};

endmodule

// File: rtl/msgtab_store.sv
module msgtab_store
  import msgtab_pkg::*;
#(
  parameter int unsigned NVEC   = 8,
  parameter int unsigned REG_AW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      addr,
  input  logic [31:0]            wr_data,
  output logic [31:0]            rd_data,
  output logic [NVEC-1:0]        vmask,
  input  logic [$clog2(NVEC > 1 ? NVEC : 2)-1:0] sel_vec,
  output msgtab_msg_t            sel_msg
);

  localparam int unsigned EW = $clog2(NVEC > 1 ? NVEC : 2);
  localparam int unsigned IW = REG_AW - 4;

  logic [31:0]     lo_q  [NVEC];
  logic [31:0]     hi_q  [NVEC];
  logic [31:0]     dat_q [NVEC];
  logic [31:0]     lo_d  [NVEC];
  logic [31:0]     hi_d  [NVEC];
  logic [31:0]     dat_d [NVEC];
  logic [NVEC-1:0] msk_q, msk_d;

  logic [IW-1:0]   ent_idx;
  logic            ent_hit;
  logic [EW-1:0]   ent;
  logic [1:0]      word;

  assign ent_idx = addr[REG_AW-1:4];
  assign ent_hit = (32'(ent_idx) < NVEC);
  assign ent     = EW'(ent_idx);
  assign word    = addr[3:2];

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    dat_d = dat_q;
    msk_d = msk_q;
    if (wr_en && ent_hit) begin
      case (word)
        2'd0:    lo_d[ent]  = wr_data;
        2'd1:    hi_d[ent]  = wr_data;
        2'd2:    dat_d[ent] = wr_data;
        default: msk_d[ent] = wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
      msk_q <= '1;
    end else begin
      for (int i = 0; i < NVEC; i++) begin
        lo_q[i]  <= lo_d[i];
        hi_q[i]  <= hi_d[i];
        dat_q[i] <= dat_d[i];
      end
      msk_q <= msk_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (ent_hit) begin
      case (word)
        2'd0:    rd_data = lo_q[ent];
        2'd1:    rd_data = hi_q[ent];
        2'd2:    rd_data = dat_q[ent];
        default: rd_data = {31'd0, msk_q[ent]};
      endcase
    end
  end

  assign vmask        = msk_q;
  assign sel_msg.addr = {hi_q[sel_vec], lo_q[sel_vec]};
  assign sel_msg.data = dat_q[sel_vec];

endmodule

// File: rtl/msgtab_pend.sv
module msgtab_pend
  import msgtab_pkg::*;
#(
  parameter int unsigned NVEC   = 8,
  parameter int unsigned REG_AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_ok,
  input  logic [$clog2(NVEC > 1 ? NVEC : 2)-1:0] req_vec,
  input  logic [NVEC-1:0]      effm,
  input  logic [NVEC-1:0]      clr_launch,
  output logic [NVEC-1:0]      launch,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [31:0]          rd_data
);

  localparam int unsigned PBA_BITS = ((NVEC + 63) / 64) * 64;
  localparam int unsigned PBA_W    = PBA_BITS / 32;
  localparam int unsigned PIW      = $clog2(PBA_W);
  localparam int unsigned WIW      = REG_AW - 2;

  logic [NVEC-1:0]     pend_q, pend_d;
  logic [NVEC-1:0]     launch_q, launch_d;
  logic [NVEC-1:0]     effm_q;
  logic [NVEC-1:0]     unmask, fire;
  logic [PBA_BITS-1:0] pba_flat;
  logic [31:0]         pba_word [PBA_W];
  logic [WIW-1:0]      rd_widx;

  assign unmask = effm_q & ~effm;
  assign fire   = pend_q & unmask;

  always_comb begin
    pend_d   = pend_q & ~fire;
    launch_d = (launch_q | fire) & ~clr_launch;
    if (req_ok) begin
      if (effm[req_vec]) pend_d[req_vec]   = 1'b1;
      else               launch_d[req_vec] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      launch_q <= '0;
      effm_q   <= '1;
    end else begin
      pend_q   <= pend_d;
      launch_q <= launch_d;
      effm_q   <= effm;
    end
  end

  assign launch = launch_q;

  for (genvar b = 0; b < PBA_BITS; b++) begin : g_pba_bit
    if (b < NVEC) begin : g_live
      assign pba_flat[b] = pend_q[b];
    end else begin : g_pad
      assign pba_flat[b] = 1'b0;
    end
  end

  for (genvar w = 0; w < PBA_W; w++) begin : g_pba_word
    assign pba_word[w] = pba_flat[w*32 +: 32];
  end

  assign rd_widx = rd_addr[REG_AW-1:2];
  assign rd_data = (32'(rd_widx) < PBA_W) ? pba_word[PIW'(rd_widx)] : 32'd0;

  AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~effm_q) == '0); // R7

  AST_MASKED_REQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && effm[req_vec]) |=> pend_q[$past(req_vec)]); // R6

  AST_CLR_ONLY_LAUNCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_launch & ~launch_q) == '0); // R8

endmodule

// File: rtl/msgtab_issue.sv
module msgtab_issue
  import msgtab_pkg::*;
#(
  parameter int unsigned NVEC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NVEC-1:0]      launch,
  output logic [$clog2(NVEC > 1 ? NVEC : 2)-1:0] sel_vec,
  input  msgtab_msg_t          sel_msg,
  output logic [NVEC-1:0]      clr_launch,
  output logic                 msg_req,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data,
  input  logic                 msg_ack
);

  localparam int unsigned EW = $clog2(NVEC > 1 ? NVEC : 2);

  msgtab_iss_e st_q, st_d;
  msgtab_msg_t msg_q, msg_d;
  logic [EW-1:0] pick;
  logic          any;

  always_comb begin
    pick = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (launch[i]) pick = EW'(i);
    end
  end

  assign any     = |launch;
  assign sel_vec = pick;

  always_comb begin
    st_d       = st_q;
    msg_d      = msg_q;
    clr_launch = '0;
    case (st_q)
      ISS_IDLE: begin
        if (any) begin
          st_d             = ISS_BUSY;
          msg_d            = sel_msg;
          clr_launch[pick] = 1'b1;
        end
      end
      default: begin
        if (msg_ack) st_d = ISS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ISS_IDLE;
      msg_q <= '0;
    end else begin
      st_q  <= st_d;
      msg_q <= msg_d;
    end
  end

  assign msg_req  = (st_q == ISS_BUSY);
  assign msg_addr = msg_q.addr;
  assign msg_data = msg_q.data;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data))); // R5

  AST_START_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_req) |-> $past(any)); // R8

endmodule

// File: rtl/msgtab_top.sv
module msgtab_top
  import msgtab_pkg::*;
#(
  parameter int unsigned NVEC   = 8,
  parameter int unsigned REG_AW = 16,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  output logic [15:0]       ctl_rdata,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NVEC-1:0]   vec_inuse,
  input  logic              irq_valid,
  input  logic [IDX_W-1:0]  irq_vec,
  output logic              msg_req,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  input  logic              msg_ack
);

  localparam int unsigned EW = $clog2(NVEC > 1 ? NVEC : 2);

  logic            fmask;
  logic [NVEC-1:0] vmask, effm, launch, clr_launch;
  logic [EW-1:0]   sel_vec, req_vec;
  msgtab_msg_t     sel_msg;
  logic [31:0]     tbl_rd, pba_rd;
  logic            in_range, req_ok;

  assign in_range = (32'(irq_vec) < NVEC);
  assign req_vec  = EW'(irq_vec);
  assign req_ok   = irq_valid && in_range && vec_inuse[req_vec];
  assign effm     = {NVEC{fmask}} | vmask;

  msgtab_ctl #(.NVEC(NVEC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .fmask(fmask)
  );

  msgtab_store #(.NVEC(NVEC), .REG_AW(REG_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && !reg_sel), .addr(reg_addr),
    .wr_data(reg_wdata), .rd_data(tbl_rd), .vmask(vmask),
    .sel_vec(sel_vec), .sel_msg(sel_msg)
  );

  msgtab_pend #(.NVEC(NVEC), .REG_AW(REG_AW)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_ok(req_ok), .req_vec(req_vec),
    .effm(effm), .clr_launch(clr_launch), .launch(launch),
    .rd_addr(reg_addr), .rd_data(pba_rd)
  );

  msgtab_issue #(.NVEC(NVEC)) u_issue (
    .clk(clk), .rst_n(rst_n), .launch(launch), .sel_vec(sel_vec),
    .sel_msg(sel_msg), .clr_launch(clr_launch), .msg_req(msg_req),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
  );

  assign reg_rdata = reg_sel ? pba_rd : tbl_rd;

endmodule

// File: tb/msgtab_top_test.sv
`timescale 1ns/1ps
module msgtab_top_test;

  localparam int NVEC   = 8;
  localparam int REG_AW = 16;
  localparam int IDX_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NVEC-1:0] vec_inuse = '1;
  logic irq_valid = 1'b0;
  logic [IDX_W-1:0] irq_vec = '0;
  logic msg_req;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic msg_ack = 1'b0;

  always #4 clk = ~clk;

  msgtab_top #(.NVEC(NVEC), .REG_AW(REG_AW), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_inuse(vec_inuse), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_ack(msg_ack)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_lo [NVEC];
  logic [31:0] m_hi [NVEC];
  logic [31:0] m_dat[NVEC];
  logic [NVEC-1:0] m_msk;
  logic [NVEC-1:0] m_pend;
  logic m_en, m_ma;

  logic [95:0] exp_q[$];
  logic [95:0] obs_q[$];

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NVEC-1:0] eff_vec();
    return {NVEC{~m_en | m_ma}} | m_msk;
  endfunction

  task automatic replay(input logic [NVEC-1:0] old);
    logic [NVEC-1:0] now = eff_vec();
    for (int v = 0; v < NVEC; v++) begin
      if (old[v] && !now[v] && m_pend[v]) begin
        m_pend[v] = 1'b0;
        exp_q.push_back({m_hi[v], m_lo[v], m_dat[v]});
      end
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < NVEC; v++) begin
      m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0;
    end
    m_msk = '1; m_pend = '0; m_en = 1'b0; m_ma = 1'b0;
  endtask

  // responder: random acknowledge latency, records each accepted message
  initial begin
    forever begin
      @(negedge clk);
      if (msg_req && !msg_ack && ($urandom % 3 != 0)) begin
        msg_ack = 1'b1;
        obs_q.push_back({msg_addr, msg_data});
      end else begin
        msg_ack = 1'b0;
      end
    end
  end

  task automatic tbl_write(input int ent, input int word, input logic [31:0] d);
    logic [NVEC-1:0] old = eff_vec();
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0;
    reg_addr = REG_AW'(ent * 16 + word * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (ent < NVEC) begin
      case (word)
        0: m_lo[ent] = d;
        1: m_hi[ent] = d;
        2: m_dat[ent] = d;
        default: m_msk[ent] = d[0];
      endcase
    end
    replay(old);
  endtask

  task automatic pba_write(input int w, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_addr = REG_AW'(w * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic en, input logic ma);
    logic [NVEC-1:0] old = eff_vec();
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {en, ma, 14'h3abc};
    @(negedge clk);
    ctl_wr = 1'b0;
    m_en = en; m_ma = ma;
    replay(old);
  endtask

  task automatic irq(input int v);
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = IDX_W'(v);
    @(negedge clk);
    irq_valid = 1'b0;
    if (v < NVEC && vec_inuse[v]) begin
      if (eff_vec()[v]) m_pend[v] = 1'b1;
      else exp_q.push_back({m_hi[v], m_lo[v], m_dat[v]});
    end
  endtask

  task automatic rd(input logic sel, input int a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_addr = REG_AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic drain_and_compare(input string tag);
    logic [31:0] d;
    repeat (60) @(negedge clk);
    chk({tag, " message count"}, 96'(obs_q.size()), 96'(exp_q.size()));
    while (exp_q.size() > 0 && obs_q.size() > 0)
      chk({tag, " message"}, obs_q.pop_front(), exp_q.pop_front());
    exp_q.delete(); obs_q.delete();
    rd(1'b1, 0, d);
    chk({tag, " pending word"}, 96'(d), 96'(m_pend));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset state and control field layout
    chk("R2 ctl after reset", 96'(ctl_rdata), 96'(16'(NVEC - 1)));
    for (int v = 0; v < NVEC; v++) begin
      rd(1'b0, v * 16 + 12, d); chk("R1 mask bit set", 96'(d), 96'd1);
      rd(1'b0, v * 16 + 0, d);  chk("R1 addr zero", 96'(d), 96'd0);
      rd(1'b0, v * 16 + 8, d);  chk("R1 data zero", 96'(d), 96'd0);
    end
    rd(1'b1, 0, d); chk("R1 pending zero", 96'(d), 96'd0);

    // R1 / R3: disabled function masks requests even with vector unmasked
    tbl_write(0, 3, 32'h0);
    irq(0);
    drain_and_compare("R1 request pends in reset state");

    // program table
    for (int v = 0; v < NVEC; v++) begin
      tbl_write(v, 0, $urandom & 32'hffff_fffc);
      tbl_write(v, 1, $urandom);
      tbl_write(v, 2, $urandom);
    end
    // R9 layout readback
    rd(1'b0, 3 * 16 + 4, d); chk("R9 word 1 readback", 96'(d), 96'(m_hi[3]));
    rd(1'b0, 5 * 16 + 8, d); chk("R9 word 2 readback", 96'(d), 96'(m_dat[5]));
    tbl_write(NVEC, 2, 32'hdead_beef);
    rd(1'b0, NVEC * 16 + 8, d); chk("R9 beyond table reads zero", 96'(d), 96'd0);
    tbl_write(2, 3, 32'hffff_fffe);
    rd(1'b0, 2 * 16 + 12, d); chk("R9 control reserved bits", 96'(d), 96'd0);
    tbl_write(2, 3, 32'h1);

    // R7: enabling unmasks vector 0, whose pending bit replays
    ctl_write(1'b1, 1'b0);
    chk("R2 enable bit reads back", 96'(ctl_rdata), 96'({2'b10, 14'(NVEC - 1)}));
    drain_and_compare("R7 replay on enable");

    // R5 unmasked request
    for (int v = 1; v < NVEC; v++) tbl_write(v, 3, 32'h0);
    irq(4);
    drain_and_compare("R5 direct message");

    // R4 out of range and not in use
    irq(NVEC); irq(255);
    vec_inuse[6] = 1'b0; irq(6); vec_inuse[6] = 1'b1;
    drain_and_compare("R4 dropped requests");

    // R6 masked vector, repeated requests collapse
    tbl_write(2, 3, 32'h1);
    irq(2); irq(2); irq(2);
    drain_and_compare("R6 single pending bit");
    tbl_write(2, 3, 32'h0);
    drain_and_compare("R7 replay on vector unmask");

    // R8 ordering through mask-all
    ctl_write(1'b1, 1'b1);
    irq(5); irq(1); irq(7); irq(3);
    drain_and_compare("R3 mask-all pends");
    ctl_write(1'b1, 1'b0);
    drain_and_compare("R8 ascending replay");

    // R3 disabled function masks
    ctl_write(1'b0, 1'b0);
    irq(1);
    drain_and_compare("R3 disabled pends");

    // R10 pending read-only and padding
    pba_write(0, 32'h0);
    pba_write(1, 32'hffff_ffff);
    rd(1'b1, 0, d); chk("R10 write ignored", 96'(d), 96'(m_pend));
    rd(1'b1, 4, d); chk("R10 padding word zero", 96'(d), 96'd0);
    ctl_write(1'b1, 1'b0);
    drain_and_compare("R7 replay after re-enable");

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int op = $urandom % 6;
      case (op)
        0, 1: irq($urandom % (NVEC + 2));
        2: tbl_write($urandom % NVEC, 3, {$urandom, 1'b0} | 32'($urandom % 2));
        3: ctl_write(($urandom % 4) != 0, ($urandom % 3) == 0);
        4: tbl_write($urandom % (NVEC + 1), $urandom % 3, $urandom);
        default: begin
          pba_write($urandom % 2, $urandom);
          vec_inuse = NVEC'($urandom) | NVEC'(8'h0f);
        end
      endcase
      drain_and_compare("R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule